// File: doc/BRIEF.md
# Truth-Table Programmable Integer ALU

This block is an N-bit integer ALU (16 bits by default) in which every operation passes through one carry path. Each bit position holds a small propagate cell that looks up a 4-bit truth table, indexed by the operand bit pair, and a generate cell that picks one of three fixed functions. A ripple carry chain and a final XOR per bit then form the result. Addition, subtraction and every two-input bitwise function share this hardware. Logic operations force the generate terms and the carry-in to zero, so the result equals the looked-up function. Subtraction changes the propagate and generate definitions and sets the carry-in to one, so B is never inverted by a separate multiplexer.

The result and the carry-out are captured in a register on a load strobe. The registered value appears on the outputs only while an output enable is high. When the enable is low, the outputs read as zero.

Top module: `tt_alu`

## Requirements
- R1: A synchronous active-high reset clears the stored result and carry, so after reset, with output enable high, both outputs read zero.
- R2: Opcode ADD (op_i = 2'b00) stores (A + B) mod 2^N as the result and bit N of the full sum as the carry.
- R3: Opcode SUB (op_i = 2'b01) stores (A + ~B + 1) mod 2^N as the result, and the carry is 1 exactly when A >= B as unsigned numbers.
- R4: Opcode LOGIC (op_i = 2'b10, with 2'b11 treated the same way) stores, in result bit i, bit tt_i[2*A_i + B_i] of the truth-table word, and the stored carry is 0.
- R5: Under LOGIC, the truth-table codes 4'b0110, 4'b1000 and 4'b1110 give A XOR B, A AND B and A OR B.
- R6: Under ADD and SUB the truth-table input has no effect on the stored result or carry.
- R7: While ld_i is low the stored result and carry keep their values.
- R8: While oe_i is low, res_o and cout_o both read zero, and the stored value is not disturbed. It reappears when oe_i goes high again.
- R9: A load sampled high on a rising clock edge is visible on the outputs right after that edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Operation: 00 ADD, 01 SUB, 10/11 LOGIC |
| tt_i | input | 4 | Truth table for LOGIC, indexed by {A_i, B_i} |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| ld_i | input | 1 | Capture the new result and carry at the clock edge |
| oe_i | input | 1 | Drive the stored result and carry onto the outputs |
| res_o | output | W | Stored result, or zero when not enabled |
| cout_o | output | 1 | Stored carry-out, or zero when not enabled |

## Verification
Additions are tried with carries that ripple the full width (all-ones plus one) and with operands that produce no carry, which shows whether the chain links every bit and whether the carry is taken from the top bit. Subtractions cover equal operands, A below B and A above B, which tells a correct borrow sense from an inverted one. Logic operations go through the XOR, AND and OR codes, then all sixteen truth-table values on operands holding every bit pair, which exposes a swapped index order or a generate term that leaks into the result. Stretches with the load low, the enable low and a junk truth table under arithmetic show that held state is kept, that gating does not touch storage and that the table is ignored.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_LOGIC = 2'b10,
        OP_LOGX  = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        GS_ZERO = 2'b00,
        GS_AND  = 2'b01,
        GS_ANDN = 2'b10
    } gen_sel_e;

    // truth tables indexed by {a,b}
    localparam logic [3:0] TT_XOR  = 4'b0110;
    localparam logic [3:0] TT_XNOR = 4'b1001;

endpackage

// File: rtl/tt_alu_ctrl.sv
module tt_alu_ctrl
    import tt_alu_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic [3:0] tt_i,
    output logic [3:0] tt_eff_o,
    output gen_sel_e   gsel_o,
    output logic       cin_o
);

    always_comb begin
        tt_eff_o = tt_i;
        gsel_o   = GS_ZERO;
        cin_o    = 1'b0;
        unique case (alu_op_e'(op_i))
            OP_ADD: begin
                tt_eff_o = TT_XOR;
                gsel_o   = GS_AND;
                cin_o    = 1'b0;
            end
            OP_SUB: begin
                tt_eff_o = TT_XNOR;
                gsel_o   = GS_ANDN;
                cin_o    = 1'b1;
            end
            OP_LOGIC, OP_LOGX: begin
                tt_eff_o = tt_i;
                gsel_o   = GS_ZERO;
                cin_o    = 1'b0;
            end
            default: begin
                tt_eff_o = tt_i;
                gsel_o   = GS_ZERO;
                cin_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tt_alu_pg.sv
module tt_alu_pg
    import tt_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   tt_i,
    input  gen_sel_e     gsel_i,
    output logic [W-1:0] p_o,
    output logic [W-1:0] g_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] idx;
        assign idx    = {a_i[i], b_i[i]};
        assign p_o[i] = tt_i[idx];

        always_comb begin
            unique case (gsel_i)
                GS_AND:  g_o[i] = a_i[i] & b_i[i];
                GS_ANDN: g_o[i] = a_i[i] & ~b_i[i];
                default: g_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tt_alu_chain.sv
module tt_alu_chain #(
    parameter int W = 16
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] g_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] c;
    assign c[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign c[i+1]   = g_i[i] | (p_i[i] & c[i]);
        assign sum_o[i] = p_i[i] ^ c[i];
    end

    assign cout_o = c[W];

    // with no generate and no carry-in the chain must pass P through
    always_comb begin
        if (g_i == '0 && !cin_i) begin
            AST_LOGIC_PASS: assert (sum_o == p_i && !cout_o); // R4
        end
    end

endmodule

// File: rtl/tt_alu.sv
module tt_alu
    import tt_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [1:0]   op_i,
    input  logic [3:0]   tt_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ld_i,
    input  logic         oe_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         co;
    } state_t;

    logic [3:0]   tt_eff;
    gen_sel_e     gsel;
    logic         cin;
    logic [W-1:0] p, g, sum;
    logic         chain_co;
    state_t       st_d, st_q;

    tt_alu_ctrl u_ctrl (
        .op_i     (op_i),
        .tt_i     (tt_i),
        .tt_eff_o (tt_eff),
        .gsel_o   (gsel),
        .cin_o    (cin)
    );

    tt_alu_pg #(.W(W)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .tt_i   (tt_eff),
        .gsel_i (gsel),
        .p_o    (p),
        .g_o    (g)
    );

    tt_alu_chain #(.W(W)) u_chain (
        .p_i    (p),
        .g_i    (g),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (chain_co)
    );

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.res = sum;
            st_d.co  = chain_co;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o  = oe_i ? st_q.res : '0;
    assign cout_o = oe_i ? st_q.co  : 1'b0;

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (st_q.res == '0 && !st_q.co)); // R1

    AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_i && op_i == 2'b00) |=>
            ({st_q.co, st_q.res} == $past({1'b0, a_i} + {1'b0, b_i}))); // R2

    AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_i && op_i == 2'b01) |=>
            (st_q.res == $past(a_i - b_i) && st_q.co == $past(a_i >= b_i))); // R3

    AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
        !ld_i |=> $stable(st_q)); // R7

    AST_OE_GATE: assert property (@(posedge clk_i) disable iff (rst_i)
        !oe_i |-> (res_o == '0 && !cout_o)); // R8

endmodule

// File: tb/tt_alu_tb_top.sv
module tt_alu_tb_top;

    localparam int W = 16;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   op;
    logic [3:0]   tt;
    logic [W-1:0] a, b;
    logic         ld, oe;
    logic [W-1:0] res;
    logic         cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    tt_alu #(.W(W)) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .op_i   (op),
        .tt_i   (tt),
        .a_i    (a),
        .b_i    (b),
        .ld_i   (ld),
        .oe_i   (oe),
        .res_o  (res),
        .cout_o (cout)
    );

    // behavioural reference: stored value and the requirement tag of its origin
    logic [W-1:0] m_res;
    logic         m_co;
    string        m_tag;

    function automatic logic [W:0] ref_op(logic [1:0] o, logic [3:0] t,
                                          logic [W-1:0] x, logic [W-1:0] y);
        logic [W:0] r;
        r = '0;
        if (o == 2'b00) begin
            r = {1'b0, x} + {1'b0, y};
        end else if (o == 2'b01) begin
            r[W-1:0] = x - y;
            r[W]     = (x >= y);
        end else begin
            for (int i = 0; i < W; i++) begin
                r[i] = t[x[i] * 2 + y[i]];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_res <= '0;
            m_co  <= 1'b0;
            m_tag <= "R1";
        end else if (ld) begin
            logic [W:0] r;
            r = ref_op(op, tt, a, b);
            m_res <= r[W-1:0];
            m_co  <= r[W];
            m_tag <= (op == 2'b00) ? "R2 R9" : (op == 2'b01) ? "R3 R9" : "R4 R5 R9";
        end else begin
            m_tag <= (m_tag == "R1") ? "R1" : "R7";
        end
    end

    task automatic compare(string extra);
        logic [W-1:0] er;
        logic         ec;
        string        tag;
        er  = oe ? m_res : '0;
        ec  = oe ? m_co  : 1'b0;
        tag = oe ? {m_tag, extra} : "R8";
        n_checks++;
        if (res !== er || cout !== ec) begin
            n_fail++;
            $display("FAIL %s: res=%h cout=%b expected res=%h cout=%b",
                     tag, res, cout, er, ec);
        end
    endtask

    // compare outputs of the previous edge, then drive the next inputs
    task automatic step(logic [1:0] o, logic [3:0] t, logic [W-1:0] x,
                        logic [W-1:0] y, logic l, logic e, string extra);
        @(negedge clk);
        compare(extra);
        op = o; tt = t; a = x; b = y; ld = l; oe = e;
    endtask

    initial begin
        rst = 1'b1; op = 2'b00; tt = 4'h0; a = '0; b = '0; ld = 1'b0; oe = 1'b1;
        repeat (3) @(negedge clk);
        compare(""); // R1 while reset holds
        rst = 1'b0;
        step(2'b00, 4'h0, 16'h1234, 16'h4321, 1'b0, 1'b1, ""); // R1 after reset
        // R2 full ripple, no carry, top carry
        step(2'b00, 4'h5, ONES, 16'h0001, 1'b1, 1'b1, "");
        step(2'b00, 4'h0, 16'h0F0F, 16'h3030, 1'b1, 1'b1, "");
        step(2'b00, 4'hA, 16'h8000, 16'h8000, 1'b1, 1'b1, " R6");
        // R3 equal, below, above
        step(2'b01, 4'h3, 16'h5555, 16'h5555, 1'b1, 1'b1, " R6");
        step(2'b01, 4'h0, 16'h0001, 16'h0002, 1'b1, 1'b1, "");
        step(2'b01, 4'hF, 16'hF000, 16'h0FFF, 1'b1, 1'b1, "");
        step(2'b01, 4'h0, 16'h0000, ONES, 1'b1, 1'b1, "");
        // R5 named codes
        step(2'b10, 4'b0110, 16'hFF00, 16'hF0F0, 1'b1, 1'b1, "");
        step(2'b10, 4'b1000, 16'hFF00, 16'hF0F0, 1'b1, 1'b1, "");
        step(2'b10, 4'b1110, 16'hFF00, 16'hF0F0, 1'b1, 1'b1, "");
        // R4 every table, both logic encodings
        for (int t = 0; t < 16; t++) begin
            step((t % 2 == 0) ? 2'b10 : 2'b11, 4'(t), 16'hCC3A, 16'hAA5C, 1'b1, 1'b1, "");
        end
        // R7 hold with changing inputs
        step(2'b00, 4'h0, 16'h7777, 16'h1111, 1'b1, 1'b1, "");
        for (int k = 0; k < 4; k++) begin
            step(2'(k), 4'(k), 16'(k * 999), 16'(k * 77), 1'b0, 1'b1, "");
        end
        // R8 gating, then state returns
        step(2'b01, 4'h0, 16'h9000, 16'h1000, 1'b1, 1'b0, "");
        step(2'b00, 4'h0, 16'h0, 16'h0, 1'b0, 1'b0, "");
        step(2'b00, 4'h0, 16'h0, 16'h0, 1'b0, 1'b1, "");
        step(2'b00, 4'h0, 16'h0, 16'h0, 1'b0, 1'b1, "");
        // random mix
        for (int k = 0; k < 300; k++) begin
            step(2'($urandom), 4'($urandom), 16'($urandom), 16'($urandom),
                 1'($urandom), ($urandom % 4) != 0, "");
        end
        step(2'b00, 4'h0, 16'h0, 16'h0, 1'b0, 1'b1, "");
        // reset in the middle of operation
        step(2'b00, 4'h0, ONES, ONES, 1'b1, 1'b1, "");
        @(negedge clk);
        compare("");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step(2'b00, 4'h0, 16'h0, 16'h0, 1'b0, 1'b1, ""); // R1 clear after run
        @(negedge clk);
        compare("");
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

endmodule